// File: doc/BRIEF.md
# Priority Address-Match Word Substitution Unit

This unit sits on a 16-bit word bus between a processor and a cartridge ROM and watches each ROM access. It holds six patch slots, each made of a word address (address lines 23 down to 1), a 16-bit replacement word and an enable bit. When the incoming ROM chip select falls, the current address is compared with every enabled slot. If any slot matches, the ROM select to the cartridge is held inactive for the whole access. The replacement word of the lowest-numbered matching slot is then driven onto the data bus while the read strobe is low.

Slot contents come in as plain inputs, so a register file elsewhere can program them. An external switch input turns all slots off together. When no slot matches, the chip select passes through unchanged and the data-drive enable stays low. Each access is judged once, on the falling edge of chip select. That decision stays in force until chip select rises, and the next fall evaluates the slots again.

Top module: `word_patch_unit`

## Requirements
- R1: Each slot compares its 23-bit word address with address lines 23..1. A difference in any one bit, including line 1, is a miss. No byte-lane input exists, so substitution is always a whole word.
- R2: The compare is made in the clock cycle in which `cs_n_in` is first seen low after being high. The read strobe plays no part in it. On a hit, `cs_n_out` is high in that same cycle.
- R3: When several enabled slots match, the replacement word comes from the lowest-numbered one. Slot 0 is the lowest, and slot i occupies bits [i*23 +: 23] of `slot_addr` and [i*16 +: 16] of `slot_data`.
- R4: After a hit, `cs_n_out` stays high and the replacement word stays fixed for as long as `cs_n_in` stays low. This holds even if the address or slot inputs change during the access.
- R5: `dout_oe` is 1 only while a hit is in force and `rd_n` and `cs_n_in` are both low. Whenever `dout_oe` is 0, `dout` is 0.
- R6: An access that hits but never lowers `rd_n` drives nothing. The unit re-arms when `cs_n_in` rises, and the next fall makes a fresh compare.
- R7: A slot whose bit in `slot_en` is 0 never matches.
- R8: When `sw_enable` is 0, no slot matches.
- R9: On a miss, `cs_n_out` equals `cs_n_in` and `dout_oe` is 0.
- R10: During synchronous active-low reset, any stored hit is cleared. With `cs_n_in` high, `cs_n_out` is high and `dout_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock synchronous with the processor bus |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 23 | Address lines 23..1 |
| cs_n_in | input | 1 | ROM chip select from the system, active low |
| rd_n | input | 1 | Read strobe, active low |
| slot_addr | input | 138 | Six packed 23-bit slot word addresses |
| slot_data | input | 96 | Six packed 16-bit replacement words |
| slot_en | input | 6 | Per-slot enable, bit i for slot i |
| sw_enable | input | 1 | Global code-enable switch, 1 = codes active |
| cs_n_out | output | 1 | Chip select to the cartridge ROM, active low |
| dout | output | 16 | Replacement word |
| dout_oe | output | 1 | Drive enable for `dout` |

## Verification
Two things can happen in the same cycle: the compare at the chip-select fall, and the start of the data drive. The bench provokes this by lowering `cs_n_in` and `rd_n` together, so the hit must block the ROM select and present the lowest slot's word in that very cycle. It also changes the address and slot data in the middle of an access to check that the decision taken at the fall is the one that holds. A behavioural model with its own fall detector and lowest-first search is compared against all three outputs on every clock.

// File: rtl/patch_pkg.sv
// Package: default geometry shared by the substitution unit and its parts.
// Assumes a word-addressed bus; address line 0 does not exist on it.
package patch_pkg;
    localparam int unsigned DEF_SLOTS  = 6;
    localparam int unsigned DEF_AWIDTH = 23;
    localparam int unsigned DEF_DWIDTH = 16;
endpackage

// File: rtl/patch_slot_match.sv
// Per-slot address comparators. Each slot reports a hit when it is enabled,
// the global switch is on, and its stored word address equals the bus address.
// Assumes the slot addresses are packed slot 0 in the lowest bits.
module patch_slot_match #(
    parameter int unsigned SLOTS  = patch_pkg::DEF_SLOTS,
    parameter int unsigned AWIDTH = patch_pkg::DEF_AWIDTH
) (
    input  logic [AWIDTH-1:0]       addr,
    input  logic [SLOTS*AWIDTH-1:0] slot_addr,
    input  logic [SLOTS-1:0]        slot_en,
    input  logic                    sw_enable,
    output logic [SLOTS-1:0]        hit_vec
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Compare one slot's full word address against the bus.
        always_comb begin
            hit_vec[g] = sw_enable && slot_en[g] &&
                         (slot_addr[g*AWIDTH +: AWIDTH] == addr);
        end
    end
endmodule

// File: rtl/patch_prio_pick.sv
// Lowest-index-wins selector. Picks the replacement word of the lowest
// numbered slot whose hit bit is set and flags whether any slot hit.
// Assumes replacement words are packed slot 0 in the lowest bits.
module patch_prio_pick #(
    parameter int unsigned SLOTS  = patch_pkg::DEF_SLOTS,
    parameter int unsigned DWIDTH = patch_pkg::DEF_DWIDTH
) (
    input  logic [SLOTS-1:0]        hit_vec,
    input  logic [SLOTS*DWIDTH-1:0] slot_data,
    output logic                    any_hit,
    output logic [DWIDTH-1:0]       sel_data
);
    // Walk from the highest slot down so that lower slots override.
    always_comb begin
        sel_data = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel_data = slot_data[i*DWIDTH +: DWIDTH];
            end
        end
    end

    // Flag any hit at all.
    always_comb begin
        any_hit = |hit_vec;
    end
endmodule

// File: rtl/patch_cycle_ctrl.sv
// Access sequencer. Detects the chip-select fall, captures the hit decision
// and the chosen word, keeps the ROM select blocked until chip select rises,
// and enables the data drive while the read strobe is low.
// Assumes cs_n_in and rd_n are already synchronous to clk.
module patch_cycle_ctrl #(
    parameter int unsigned DWIDTH = patch_pkg::DEF_DWIDTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_in,
    input  logic              rd_n,
    input  logic              any_hit,
    input  logic [DWIDTH-1:0] sel_data,
    output logic              cs_n_out,
    output logic [DWIDTH-1:0] dout,
    output logic              dout_oe
);
    logic              cs_prev_q;
    logic              hit_q;
    logic [DWIDTH-1:0] data_q;
    logic              cs_fall;
    logic              hit_eff;
    logic [DWIDTH-1:0] data_eff;

    // Chip-select fall: low now, high on the previous clock.
    always_comb begin
        cs_fall = !cs_n_in && cs_prev_q;
    end

    // Remember the previous chip-select level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev_q <= 1'b1;
        end else begin
            cs_prev_q <= cs_n_in;
        end
    end

    // Capture the decision at the fall; drop it when chip select rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else if (cs_n_in) begin
            hit_q <= 1'b0;
        end else if (cs_fall) begin
            hit_q <= any_hit;
        end
    end

    // Capture the chosen word at the fall so that it stays fixed for the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (cs_fall) begin
            data_q <= sel_data;
        end
    end

    // In the fall cycle use the live compare; afterwards use the stored one.
    always_comb begin
        hit_eff  = cs_fall ? any_hit  : hit_q;
        data_eff = cs_fall ? sel_data : data_q;
    end

    // Block the ROM select on a hit; drive the word under the read strobe.
    always_comb begin
        cs_n_out = cs_n_in || hit_eff;
        dout_oe  = hit_eff && !cs_n_in && !rd_n;
        dout     = dout_oe ? data_eff : '0;
    end
endmodule

// File: rtl/word_patch_unit.sv
// Top of the word substitution unit: slot comparators, priority pick and the
// access sequencer. Assumes slot values are held steady by their owner
// and that the bus strobes are synchronous to clk.
module word_patch_unit #(
    parameter int unsigned SLOTS  = patch_pkg::DEF_SLOTS,
    parameter int unsigned AWIDTH = patch_pkg::DEF_AWIDTH,
    parameter int unsigned DWIDTH = patch_pkg::DEF_DWIDTH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AWIDTH-1:0]       addr,
    input  logic                    cs_n_in,
    input  logic                    rd_n,
    input  logic [SLOTS*AWIDTH-1:0] slot_addr,
    input  logic [SLOTS*DWIDTH-1:0] slot_data,
    input  logic [SLOTS-1:0]        slot_en,
    input  logic                    sw_enable,
    output logic                    cs_n_out,
    output logic [DWIDTH-1:0]       dout,
    output logic                    dout_oe
);
    logic [SLOTS-1:0]  hit_vec;
    logic              any_hit;
    logic [DWIDTH-1:0] sel_data;

    patch_slot_match #(.SLOTS(SLOTS), .AWIDTH(AWIDTH)) u_match (
        .addr      (addr),
        .slot_addr (slot_addr),
        .slot_en   (slot_en),
        .sw_enable (sw_enable),
        .hit_vec   (hit_vec)
    );

    patch_prio_pick #(.SLOTS(SLOTS), .DWIDTH(DWIDTH)) u_pick (
        .hit_vec   (hit_vec),
        .slot_data (slot_data),
        .any_hit   (any_hit),
        .sel_data  (sel_data)
    );

    patch_cycle_ctrl #(.DWIDTH(DWIDTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_in  (cs_n_in),
        .rd_n     (rd_n),
        .any_hit  (any_hit),
        .sel_data (sel_data),
        .cs_n_out (cs_n_out),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );
endmodule

// File: rtl/word_patch_unit_checker.sv
// Port-level protocol checks for word_patch_unit, attached with bind.
// Assumes it sees the top-level ports only.
module word_patch_unit_checker #(
    parameter int unsigned DWIDTH = patch_pkg::DEF_DWIDTH
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_in,
    input logic              rd_n,
    input logic              sw_enable,
    input logic              cs_n_out,
    input logic [DWIDTH-1:0] dout,
    input logic              dout_oe
);
    AST_DRIVE_NEEDS_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (!rd_n && !cs_n_in)); // R5

    AST_QUIET_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (dout == '0)); // R5

    AST_DRIVE_BLOCKS_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> cs_n_out); // R4

    AST_IDLE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_in |-> cs_n_out); // R9

    AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_in && !$past(cs_n_in)) |-> (cs_n_out == $past(cs_n_out))); // R4

    AST_SWITCH_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_in && $past(cs_n_in) && !sw_enable) |-> !cs_n_out); // R8
endmodule

bind word_patch_unit word_patch_unit_checker #(.DWIDTH(DWIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_in   (cs_n_in),
    .rd_n      (rd_n),
    .sw_enable (sw_enable),
    .cs_n_out  (cs_n_out),
    .dout      (dout),
    .dout_oe   (dout_oe)
);

// File: tb/word_patch_unit_test.sv
module word_patch_unit_test;
    localparam int NS = 6;
    localparam int AW = 23;
    localparam int DW = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     addr = '0;
    logic              cs_n_in = 1'b1;
    logic              rd_n = 1'b1;
    logic [AW-1:0]     sa [NS];
    logic [DW-1:0]     sd [NS];
    logic [NS*AW-1:0]  slot_addr;
    logic [NS*DW-1:0]  slot_data;
    logic [NS-1:0]     slot_en = '0;
    logic              sw_enable = 1'b1;
    logic              cs_n_out;
    logic [DW-1:0]     dout;
    logic              dout_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // model state
    bit            m_prev = 1;
    bit            m_hit = 0;
    logic [DW-1:0] m_data = '0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            slot_addr[i*AW +: AW] = sa[i];
            slot_data[i*DW +: DW] = sd[i];
        end
    end

    word_patch_unit uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n_in(cs_n_in), .rd_n(rd_n),
        .slot_addr(slot_addr), .slot_data(slot_data), .slot_en(slot_en),
        .sw_enable(sw_enable), .cs_n_out(cs_n_out), .dout(dout), .dout_oe(dout_oe)
    );

    function automatic bit search(output logic [DW-1:0] w);
        w = '0;
        if (!sw_enable) return 0;
        for (int i = 0; i < NS; i++) begin
            if (slot_en[i] && sa[i] == addr) begin
                w = sd[i];
                return 1;
            end
        end
        return 0;
    endfunction

    task automatic tick(input string tag);
        logic [DW-1:0] w;
        bit f, fall, h, e_cs, e_oe;
        logic [DW-1:0] e_d;
        #3;
        f = search(w);
        fall = !cs_n_in && m_prev;
        h = fall ? f : m_hit;
        e_cs = cs_n_in || h;
        e_oe = h && !cs_n_in && !rd_n;
        e_d = e_oe ? (fall ? w : m_data) : '0;
        n_cmp++;
        if (cs_n_out !== e_cs || dout_oe !== e_oe || dout !== e_d) begin
            n_bad++;
            $display("FAIL %s: got cs=%b oe=%b d=%h exp cs=%b oe=%b d=%h",
                     tag, cs_n_out, dout_oe, dout, e_cs, e_oe, e_d);
        end
        @(posedge clk);
        if (!rst_n) begin
            m_hit = 0; m_prev = 1;
        end else begin
            if (cs_n_in) m_hit = 0;
            else if (fall) begin m_hit = f; m_data = w; end
            m_prev = cs_n_in;
        end
        @(negedge clk);
    endtask

    task automatic access(input logic [AW-1:0] a, input bit do_rd, input string tag);
        addr = a; cs_n_in = 0; rd_n = 1; tick(tag);
        if (do_rd) begin rd_n = 0; tick(tag); tick(tag); end
        rd_n = 1; cs_n_in = 1; tick(tag);
    endtask

    initial begin
        for (int i = 0; i < NS; i++) begin
            sa[i] = 23'h100 + AW'(i * 16);
            sd[i] = 16'hA000 + DW'(i);
        end
        @(negedge clk);
        tick("R10 reset"); tick("R10 reset");
        rst_n = 1;
        tick("R10 after reset");
        slot_en = 6'b111111;
        // R9 miss
        access(23'h7F_0000, 1, "R9 miss passthrough");
        // R1 exact hit and bit-1 neighbour
        access(23'h100, 1, "R1 exact hit");
        access(23'h101, 1, "R1 low bit differs");
        access(23'h4100, 1, "R1 high bit differs");
        // R2 fall with read already low
        addr = 23'h110; cs_n_in = 0; rd_n = 0; tick("R2 fall with read low");
        tick("R2 R5 drive"); rd_n = 1; tick("R5 read released");
        cs_n_in = 1; tick("R2 end");
        // R4 address and data change mid-access
        addr = 23'h120; cs_n_in = 0; tick("R4 fall");
        addr = 23'h7000; sd[2] = 16'h5555; tick("R4 held select");
        rd_n = 0; tick("R4 held data"); tick("R4 held data");
        rd_n = 1; cs_n_in = 1; tick("R4 end");
        sd[2] = 16'hA002;
        // R4 miss held even if address becomes a match mid-access
        addr = 23'h7000; cs_n_in = 0; tick("R4 miss fall");
        addr = 23'h100; rd_n = 0; tick("R4 miss held"); tick("R4 miss held");
        rd_n = 1; cs_n_in = 1; tick("R4 miss end");
        // R3 slots 0,2,3 share an address
        sa[2] = 23'h100; sa[3] = 23'h100;
        access(23'h100, 1, "R3 lowest of 0,2,3");
        slot_en = 6'b111110;
        access(23'h100, 1, "R3 next lowest 2");
        // R7 disabled slot
        slot_en = 6'b110111; sa[2] = 23'h120; sa[3] = 23'h130;
        access(23'h130, 1, "R7 disabled slot");
        access(23'h150, 1, "R7 enabled slot 5");
        slot_en = 6'b111111;
        // R6 hit without read then fresh compare
        access(23'h140, 0, "R6 no read");
        access(23'h7F_1234, 1, "R6 rearm miss");
        addr = 23'h140; cs_n_in = 0; tick("R6 back to back");
        cs_n_in = 1; tick("R6 gap");
        addr = 23'h7F_0001; cs_n_in = 0; rd_n = 0; tick("R6 new fall miss");
        rd_n = 1; cs_n_in = 1; tick("R6 end");
        // R8 switch off
        sw_enable = 0;
        access(23'h100, 1, "R8 switch off");
        sw_enable = 1;
        access(23'h100, 1, "R8 switch on again");
        // reset mid access
        addr = 23'h110; cs_n_in = 0; tick("R10 pre");
        rst_n = 0; cs_n_in = 1; tick("R10 reset again");
        rst_n = 1; tick("R10 release");
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule